// File: doc/BRIEF.md
# Register Window Address Translator

This block turns the 4-bit register number carried in a DSP instruction operand into a 10-bit data-memory address. Two small configuration registers shape the translation. A 3-bit map mode selects how address bit 8 is formed from the upper register-number bits. A 6-bit window base, scaled by four, is XORed into the result so that software can move the register window around data memory.

Both settings are written by control instructions. The decoder places the instruction's 10-bit address field on a shared input and pulses the matching load strobe. Translation is purely combinational from the current settings. An operand fetch can therefore present a register number and use the address in the same cycle.

Top module: `regwin_xlate`

## Requirements
- R1: Before the base is applied, the mapped address places register bits 2:0 in address bits 2:0 and register bit 3 in address bit 9, and holds address bits 7:3 at zero.
- R2: With map mode 0, 1, 2 or 3, address bit 8 equals register bit 2.
- R3: With map mode 4, address bit 8 equals register bit 3; with map mode 5 it equals the inverse of register bit 3.
- R4: With map mode 6, address bit 8 is register bit 2 AND register bit 3; with map mode 7 it is register bit 2 OR register bit 3.
- R5: The output address is the mapped address XOR (base × 4), so the base affects only address bits 7:2, and bits 9:8 and 1:0 never depend on it.
- R6: A base load strobe captures cfg_field bits 5:0 and ignores bits 9:6; the new base is used from the cycle after the strobe's clock edge, and not before that edge.
- R7: A map load strobe captures cfg_field bits 2:0 and ignores bits 9:3; the new mode is used from the cycle after the strobe's clock edge, and not before that edge.
- R8: While its strobe is low, each setting keeps its value whatever cfg_field carries.
- R9: A clock edge with rst_n low sets both the base and the map mode to zero, so the output becomes the mode-0, base-0 mapping.
- R10: A change of reg_num reaches mem_addr without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_field | input | 10 | Address field of the current control instruction |
| base_load | input | 1 | Load the window base from cfg_field[5:0] |
| map_load | input | 1 | Load the map mode from cfg_field[2:0] |
| reg_num | input | 4 | Register number to translate |
| mem_addr | output | 10 | Translated data-memory address |

## Verification
The address is due in the same cycle as reg_num, so the bench changes reg_num, waits a short settling delay and compares, with no clock edge in between. A load strobe's effect is due one clock edge later. The bench applies the strobe after a falling edge and checks the old translation before the rising edge. It then checks the new translation just after that edge. The sweep covers every map mode, every base value and every register number.

// File: rtl/regwin_pkg.sv
// Package: shared widths and map-mode encodings for the register window
// translator. Assumes a 4-bit register number and a 10-bit address.
package regwin_pkg;

    localparam int REG_W   = 4;   // register number width
    localparam int ADDR_W  = 10;  // data-memory address width
    localparam int MODE_W  = 3;   // map mode width
    localparam int BASE_W  = 6;   // window base width
    localparam int BASE_SH = 2;   // base scaling shift (times four)

    // Map modes that pick the source of address bit 8.
    typedef enum logic [MODE_W-1:0] {
        MAP_LOW0 = 3'd0,
        MAP_LOW1 = 3'd1,
        MAP_LOW2 = 3'd2,
        MAP_LOW3 = 3'd3,
        MAP_HI   = 3'd4,
        MAP_NHI  = 3'd5,
        MAP_AND  = 3'd6,
        MAP_OR   = 3'd7
    } map_mode_e;

endpackage

// File: rtl/regwin_cfg_reg.sv
// Module: one configuration register of the translator.
// It loads the low WIDTH bits of the control field on a strobe, keeps its
// value otherwise, and clears on a synchronous active-low reset.
// Assumes FIELD_W >= WIDTH.
module regwin_cfg_reg #(
    parameter int WIDTH   = 3,
    parameter int FIELD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] field,
    output logic [WIDTH-1:0]   value
);

    // Capture the low field bits on a strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (load)
            value <= field[WIDTH-1:0];
    end

    // R6 / R7: a strobe places the low field bits in the register one edge later.
    p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(field[WIDTH-1:0])));

    // R8: without a strobe the register keeps its value.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(value));

endmodule

// File: rtl/regwin_map.sv
// Module: combinational register-number mapping.
// Forms the pre-base address (low bits and top bit copied, middle bits zero,
// bit 8 chosen by the map mode), then XORs in the scaled window base.
// Assumes REG_W = 4 and ADDR_W >= BASE_W + BASE_SH + 2.
module regwin_map
    import regwin_pkg::*;
#(
    parameter int RW  = REG_W,
    parameter int AW  = ADDR_W,
    parameter int MW  = MODE_W,
    parameter int BW  = BASE_W,
    parameter int SH  = BASE_SH
) (
    input  logic [RW-1:0] reg_num,
    input  logic [MW-1:0] mode,
    input  logic [BW-1:0] base,
    output logic [AW-1:0] addr
);

    localparam int LOW_W = RW - 1;          // bits copied straight through
    localparam int ZERO_W = AW - 2 - LOW_W; // zero-filled middle bits

    logic          hi_bit;   // register bit 3
    logic          mid_bit;  // register bit 2
    logic          sel_bit;  // chosen address bit 8
    logic [AW-1:0] mapped;
    logic [AW-1:0] base_sc;

    assign hi_bit  = reg_num[RW-1];
    assign mid_bit = reg_num[RW-2];

    // Choose address bit 8 from the map mode.
    always_comb begin
        case (map_mode_e'(mode))
            MAP_HI:  sel_bit = hi_bit;
            MAP_NHI: sel_bit = ~hi_bit;
            MAP_AND: sel_bit = hi_bit & mid_bit;
            MAP_OR:  sel_bit = hi_bit | mid_bit;
            default: sel_bit = mid_bit;
        endcase
    end

    // Assemble the pre-base address.
    always_comb begin
        mapped = {hi_bit, sel_bit, {ZERO_W{1'b0}}, reg_num[LOW_W-1:0]};
    end

    // Scale the base and XOR it into the address.
    always_comb begin
        base_sc = AW'({base, {SH{1'b0}}});
        addr    = mapped ^ base_sc;
    end

endmodule

// File: rtl/regwin_xlate.sv
// Module: register window address translator (top).
// Holds the map mode and window base and translates a register number into
// a data-memory address with the current settings, combinationally.
// Assumes the instruction decoder drives cfg_field and at most the strobes
// belonging to the decoded control instruction.
module regwin_xlate
    import regwin_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ADDR_W,
    parameter int MW = MODE_W,
    parameter int BW = BASE_W,
    parameter int SH = BASE_SH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_field,
    input  logic          base_load,
    input  logic          map_load,
    input  logic [RW-1:0] reg_num,
    output logic [AW-1:0] mem_addr
);

    localparam int BASE_LO = SH;           // lowest address bit the base touches
    localparam int BASE_HI = SH + BW - 1;  // highest address bit the base touches

    logic [MW-1:0] map_mode;
    logic [BW-1:0] win_base;

    // Map mode register.
    regwin_cfg_reg #(.WIDTH(MW), .FIELD_W(AW)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (map_load),
        .field (cfg_field),
        .value (map_mode)
    );

    // Window base register.
    regwin_cfg_reg #(.WIDTH(BW), .FIELD_W(AW)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (base_load),
        .field (cfg_field),
        .value (win_base)
    );

    // Combinational mapping.
    regwin_map #(.RW(RW), .AW(AW), .MW(MW), .BW(BW), .SH(SH)) u_map (
        .reg_num (reg_num),
        .mode    (map_mode),
        .base    (win_base),
        .addr    (mem_addr)
    );

    // R1 / R5: the top address bit follows register bit 3 and is never touched by the base.
    p_top_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[AW-1] == reg_num[RW-1]);

    // R5: the bits below the scaled base pass the register bits through.
    p_low_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[BASE_LO-1:0] == reg_num[BASE_LO-1:0]);

    // R3: mode 4 routes register bit 3 to address bit 8.
    p_mode_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (map_mode == MW'(4)) |-> (mem_addr[AW-2] == reg_num[RW-1]));

    // R4: mode 6 gives the AND of register bits 2 and 3.
    p_mode_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (map_mode == MW'(6)) |-> (mem_addr[AW-2] == (reg_num[RW-1] & reg_num[RW-2])));

    // R5: with a zero base the middle address bits are zero.
    p_mid_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base == '0) |-> (mem_addr[BASE_HI:RW-1] == '0));

    // R9: a reset edge leaves both settings cleared.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (map_mode == '0 && win_base == '0));

endmodule

// File: tb/regwin_xlate_bench.sv
// Bench: sweeps every map mode, base and register number, plus load timing,
// ignored field bits, hold without strobe and reset.
module regwin_xlate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_field = '0;
    logic       base_load = 1'b0;
    logic       map_load = 1'b0;
    logic [3:0] reg_num = '0;
    logic [9:0] mem_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    regwin_xlate u_regwin_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_field (cfg_field),
        .base_load (base_load),
        .map_load  (map_load),
        .reg_num   (reg_num),
        .mem_addr  (mem_addr)
    );

    // Expected address, computed from the requirements.
    function automatic logic [9:0] expect_addr(int mode, int base, int r);
        int b2, b3, b8, a;
        b2 = (r >> 2) & 1;
        b3 = (r >> 3) & 1;
        if (mode < 4)       b8 = b2;
        else if (mode == 4) b8 = b3;
        else if (mode == 5) b8 = 1 - b3;
        else if (mode == 6) b8 = b2 & b3;
        else                b8 = b2 | b3;
        a = (r & 7) + b8 * 256 + b3 * 512;
        a = a ^ ((base & 63) * 4);
        return 10'(a);
    endfunction

    task automatic check(string req, logic [9:0] exp);
        n_checks++;
        if (mem_addr !== exp) begin
            n_errors++;
            $display("FAIL %s: reg=%0d actual=%h expected=%h", req, reg_num, mem_addr, exp);
        end
    endtask

    // Load both settings with one field value and wait past the edge.
    task automatic load_both(logic [9:0] field);
        @(negedge clk);
        cfg_field = field;
        base_load = 1'b1;
        map_load  = 1'b1;
        @(posedge clk);
        #1;
        base_load = 1'b0;
        map_load  = 1'b0;
    endtask

    initial begin
        // Watchdog.
        #1500000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state is mode 0, base 0.
        for (int r = 0; r < 16; r++) begin
            reg_num = 4'(r); #1;
            check("R9 reset", expect_addr(0, 0, r));
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1-R5, R10: full sweep of modes, bases and register numbers.
        for (int m = 0; m < 8; m++) begin
            for (int b = 0; b < 64; b++) begin
                load_both(10'((b & 63) | ((b & 63) == 0 ? 0 : 0)));
                // Map mode comes from bits 2:0, base from bits 5:0 of the same field,
                // so load them in two steps to reach every pair.
                @(negedge clk);
                cfg_field = 10'(m);
                map_load  = 1'b1;
                @(posedge clk);
                #1;
                map_load  = 1'b0;
                for (int r = 0; r < 16; r++) begin
                    reg_num = 4'(r);
                    #1;
                    if (m < 4)       check("R2 mode0-3", expect_addr(m, b, r));
                    else if (m < 6)  check("R3 mode4-5", expect_addr(m, b, r));
                    else             check("R4 mode6-7", expect_addr(m, b, r));
                    if (b == 0) check("R1 pre-base layout", expect_addr(m, 0, r));
                    if (mem_addr[9:8] != expect_addr(m, 0, r) >> 8 || mem_addr[1:0] != 2'(r)) begin
                        n_checks++; n_errors++;
                        $display("FAIL R5 base reach: actual=%h expected=%h", mem_addr, expect_addr(m, b, r));
                    end else n_checks++;
                end
                // R10: reg_num change seen without a clock edge.
                reg_num = 4'd9; #1;
                check("R10 comb", expect_addr(m, b, 9));
                reg_num = 4'd6; #1;
                check("R10 comb", expect_addr(m, b, 6));
            end
        end

        // R6: base load ignores bits 9:6 and waits for the edge.
        load_both(10'h000);
        reg_num = 4'd5;
        @(negedge clk);
        cfg_field = 10'h3EA;   // bits 5:0 = 0x2A, upper ones set
        base_load = 1'b1;
        #1;
        check("R6 before edge", expect_addr(0, 0, 5));
        @(posedge clk); #1;
        base_load = 1'b0;
        check("R6 after edge", expect_addr(0, 42, 5));

        // R7: map load ignores bits 9:3 and waits for the edge.
        reg_num = 4'd8;
        @(negedge clk);
        cfg_field = 10'h3FD;   // bits 2:0 = 5
        map_load  = 1'b1;
        #1;
        check("R7 before edge", expect_addr(0, 42, 8));
        @(posedge clk); #1;
        map_load = 1'b0;
        check("R7 after edge", expect_addr(5, 42, 8));

        // R8: field changes without strobes leave both settings alone.
        @(negedge clk);
        cfg_field = 10'h1C7;
        repeat (3) @(posedge clk);
        #1;
        for (int r = 0; r < 16; r++) begin
            reg_num = 4'(r); #1;
            check("R8 hold", expect_addr(5, 42, r));
        end

        // R9: reset after use clears both settings.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        for (int r = 0; r < 16; r++) begin
            reg_num = 4'(r); #1;
            check("R9 reset again", expect_addr(0, 0, r));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule